// File: doc/BRIEF.md
# Pipelined Unsigned Multiply-Accumulate Splitter

This block takes three unsigned operands of W bits each, a multiplicand, a multiplier and an addend. It forms the exact 2W-bit sum of the product and the addend. The lower W bits of that sum leave on one output word and the upper W bits on a second output word. In a big-integer multiply loop the upper word is fed back as the next addend, so the carry limb travels from step to step with no overflow handling.

An operation is accepted when the input valid is high and the operation selector carries the code for this function. Each accepted operation also carries a destination index. The block returns that index for the lower word and the next index up for the upper word. Results come out after a fixed three-cycle latency, with a valid flag moving alongside the data. A new operation can be accepted on every cycle.

Top module: `madd_split`

## Requirements
- R1: For every accepted operation, {out_hi, out_lo} equals in_a*in_b + in_c, computed exactly on 2W bits with all operands unsigned.
- R2: out_lo carries bits W-1..0 of the R1 value and out_hi carries bits 2W-1..W. The lower word therefore equals the product-plus-addend reduced modulo 2^W.
- R3: An operation accepted at clock edge k raises out_vld, together with its data, directly after edge k+2, so three edges in all. out_vld is low in every cycle that has no operation due.
- R4: One operation is accepted on every clock edge where the accept condition holds, with no stall. Back-to-back operations come out in order, one per cycle.
- R5: An operation is accepted only when in_vld is 1 and in_op equals the 6-bit code 6'b110010. Any other in_op value, or in_vld at 0, yields no output and leaves every output unchanged.
- R6: With an output, out_lo_idx equals the in_dst of that operation and out_hi_idx equals in_dst+1 modulo 32. Both are 5 bits wide.
- R7: While rst is high at a clock edge, out_vld, out_lo, out_hi, out_lo_idx and out_hi_idx are all cleared to 0.
- R8: In any cycle where out_vld is low, out_lo and out_hi keep the values they had in the previous cycle.
- R9: With all three operands all ones, the result still fits the output: out_hi is all ones and out_lo is 0, and no overflow indication exists or is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation request |
| in_op | input | 6 | Operation selector, accepted when 6'b110010 |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| in_c | input | W | Addend, unsigned |
| in_dst | input | 5 | Destination index for the lower word |
| out_vld | output | 1 | Result valid |
| out_lo | output | W | Lower half of the result |
| out_hi | output | W | Upper half of the result |
| out_lo_idx | output | 5 | Destination index for out_lo |
| out_hi_idx | output | 5 | Destination index for out_hi (in_dst+1) |

## Verification
On every cycle the bound checker compares the output pair with a 2W-bit product-plus-addend formed from the inputs three cycles earlier. On every cycle it also checks that out_vld follows acceptance exactly three cycles later, that an unaccepted cycle produces no output three cycles later, that the index pair is consecutive, and that the data holds while out_vld is low. The bench scenarios cover the remaining behaviour. These include a full sweep of a 4-bit configuration with gaps and wrong selectors mixed into back-to-back traffic, 64-bit corner operands built from 0, 1, all ones and the half-word boundaries, the reset values, and the all-ones case that reaches the top of the output range.

// File: rtl/madd_split_pkg.sv
package madd_split_pkg;
  localparam int OP_WIDTH  = 6;
  localparam int IDX_WIDTH = 5;
  localparam int PIPE_DEPTH = 3;
  localparam logic [OP_WIDTH-1:0] OP_MADD_SPLIT = 6'b110010;
  localparam int NUM_PP = 4;
endpackage

// File: rtl/madd_pp_stage.sv
module madd_pp_stage
  import madd_split_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 vld_i,
  input  logic [OP_WIDTH-1:0]                  op_i,
  input  logic [W-1:0]                         a_i,
  input  logic [W-1:0]                         b_i,
  input  logic [W-1:0]                         c_i,
  input  logic [IDX_WIDTH-1:0]                 idx_i,
  output logic                                 vld_o,
  output logic [NUM_PP-1:0][W-1:0]             pp_o,
  output logic [W-1:0]                         c_o,
  output logic [IDX_WIDTH-1:0]                 idx_o
);
  localparam int H = W / 2;

  logic                     accept;
  logic [1:0][H-1:0]        a_half;
  logic [1:0][H-1:0]        b_half;
  logic [NUM_PP-1:0][W-1:0] pp_d;

  assign accept = vld_i && (op_i == OP_MADD_SPLIT);
  assign a_half = a_i;
  assign b_half = b_i;

  // pp index = 2*i + j : i selects the half of a, j the half of b
  for (genvar i = 0; i < 2; i++) begin : g_ahalf
    for (genvar j = 0; j < 2; j++) begin : g_bhalf
      assign pp_d[2*i+j] = {{H{1'b0}}, a_half[i]} * {{H{1'b0}}, b_half[j]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      pp_o  <= '0;
      c_o   <= '0;
      idx_o <= '0;
    end else begin
      vld_o <= accept;
      if (accept) begin
        pp_o  <= pp_d;
        c_o   <= c_i;
        idx_o <= idx_i;
      end
    end
  end
endmodule

// File: rtl/madd_sum_stage.sv
module madd_sum_stage
  import madd_split_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic [NUM_PP-1:0][W-1:0] pp_i,
  input  logic [W-1:0]             c_i,
  input  logic [IDX_WIDTH-1:0]     idx_i,
  output logic                     vld_o,
  output logic [2*W-1:0]           sum_o,
  output logic [IDX_WIDTH-1:0]     idx_o
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  logic [DW-1:0] outer_terms;
  logic [DW-1:0] cross_lo_hi;
  logic [DW-1:0] cross_hi_lo;
  logic [DW-1:0] addend_ext;
  logic [DW-1:0] sum_d;

  // ah*bh sits in the upper word, al*bl in the lower word
  assign outer_terms = {pp_i[3], pp_i[0]};
  assign cross_lo_hi = {{H{1'b0}}, pp_i[1], {H{1'b0}}};
  assign cross_hi_lo = {{H{1'b0}}, pp_i[2], {H{1'b0}}};
  assign addend_ext  = {{W{1'b0}}, c_i};
  assign sum_d = outer_terms + cross_lo_hi + cross_hi_lo + addend_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      sum_o <= '0;
      idx_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sum_o <= sum_d;
        idx_o <= idx_i;
      end
    end
  end
endmodule

// File: rtl/madd_out_stage.sv
module madd_out_stage
  import madd_split_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic [2*W-1:0]       sum_i,
  input  logic [IDX_WIDTH-1:0] idx_i,
  output logic                 vld_o,
  output logic [W-1:0]         lo_o,
  output logic [W-1:0]         hi_o,
  output logic [IDX_WIDTH-1:0] lo_idx_o,
  output logic [IDX_WIDTH-1:0] hi_idx_o
);
  localparam logic [IDX_WIDTH-1:0] IDX_ONE = {{(IDX_WIDTH-1){1'b0}}, 1'b1};

  logic [IDX_WIDTH-1:0] pair_idx;

  assign pair_idx = idx_i + IDX_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o    <= 1'b0;
      lo_o     <= '0;
      hi_o     <= '0;
      lo_idx_o <= '0;
      hi_idx_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        lo_o     <= sum_i[W-1:0];
        hi_o     <= sum_i[2*W-1:W];
        lo_idx_o <= idx_i;
        hi_idx_o <= pair_idx;
      end
    end
  end
endmodule

// File: rtl/madd_split.sv
module madd_split
  import madd_split_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [OP_WIDTH-1:0]  in_op,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic [W-1:0]         in_c,
  input  logic [IDX_WIDTH-1:0] in_dst,
  output logic                 out_vld,
  output logic [W-1:0]         out_lo,
  output logic [W-1:0]         out_hi,
  output logic [IDX_WIDTH-1:0] out_lo_idx,
  output logic [IDX_WIDTH-1:0] out_hi_idx
);
  logic                     s1_vld;
  logic [NUM_PP-1:0][W-1:0] s1_pp;
  logic [W-1:0]             s1_c;
  logic [IDX_WIDTH-1:0]     s1_idx;
  logic                     s2_vld;
  logic [2*W-1:0]           s2_sum;
  logic [IDX_WIDTH-1:0]     s2_idx;

  madd_pp_stage #(.W(W)) u_pp (
    .clk(clk), .rst(rst), .vld_i(in_vld), .op_i(in_op),
    .a_i(in_a), .b_i(in_b), .c_i(in_c), .idx_i(in_dst),
    .vld_o(s1_vld), .pp_o(s1_pp), .c_o(s1_c), .idx_o(s1_idx)
  );

  madd_sum_stage #(.W(W)) u_sum (
    .clk(clk), .rst(rst), .vld_i(s1_vld), .pp_i(s1_pp), .c_i(s1_c),
    .idx_i(s1_idx), .vld_o(s2_vld), .sum_o(s2_sum), .idx_o(s2_idx)
  );

  madd_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .vld_i(s2_vld), .sum_i(s2_sum), .idx_i(s2_idx),
    .vld_o(out_vld), .lo_o(out_lo), .hi_o(out_hi),
    .lo_idx_o(out_lo_idx), .hi_idx_o(out_hi_idx)
  );
endmodule

// File: rtl/madd_split_chk.sv
module madd_split_chk
  import madd_split_pkg::*;
#(
  parameter int W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_vld,
  input logic [OP_WIDTH-1:0]  in_op,
  input logic [W-1:0]         in_a,
  input logic [W-1:0]         in_b,
  input logic [W-1:0]         in_c,
  input logic [IDX_WIDTH-1:0] in_dst,
  input logic                 out_vld,
  input logic [W-1:0]         out_lo,
  input logic [W-1:0]         out_hi,
  input logic [IDX_WIDTH-1:0] out_lo_idx,
  input logic [IDX_WIDTH-1:0] out_hi_idx
);
  logic           take;
  logic           all_ones;
  logic [2*W-1:0] ax, bx, cx;

  assign take     = in_vld && (in_op == OP_MADD_SPLIT);
  assign all_ones = (&in_a) && (&in_b) && (&in_c);
  assign ax = {{W{1'b0}}, in_a};
  assign bx = {{W{1'b0}}, in_b};
  assign cx = {{W{1'b0}}, in_c};

  AST_EXACT_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ({out_hi, out_lo} == $past(ax * bx + cx, 3))); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    take |-> ##3 out_vld); // R3

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    !take |-> ##3 !out_vld); // R5

  AST_IDX_PAIR: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_hi_idx == out_lo_idx + 5'd1)); // R6

  AST_IDX_CARRY: assert property (@(posedge clk) disable iff (rst)
    take |-> ##3 (out_lo_idx == $past(in_dst, 3))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_lo) && $stable(out_hi))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (take && all_ones) |-> ##3 ((&out_hi) && (out_lo == '0))); // R9
endmodule

bind madd_split madd_split_chk #(.W(W)) u_madd_split_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
  .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_dst(in_dst),
  .out_vld(out_vld), .out_lo(out_lo), .out_hi(out_hi),
  .out_lo_idx(out_lo_idx), .out_hi_idx(out_hi_idx)
);

// File: tb/test_madd_split.sv
`timescale 1ns/1ps
module test_madd_split;
  localparam int BW = 64;
  localparam int SW = 4;
  localparam logic [5:0] OPC = 6'b110010;

  typedef struct {
    int           due;
    logic [127:0] val;
    logic [4:0]   idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  // wide instance
  logic          b_vld = 1'b0;
  logic [5:0]    b_op = '0;
  logic [BW-1:0] b_a = '0, b_b = '0, b_c = '0;
  logic [4:0]    b_dst = '0;
  logic          b_ovld;
  logic [BW-1:0] b_lo, b_hi;
  logic [4:0]    b_loi, b_hii;

  // small instance
  logic          s_vld = 1'b0;
  logic [5:0]    s_op = '0;
  logic [SW-1:0] s_a = '0, s_b = '0, s_c = '0;
  logic [4:0]    s_dst = '0;
  logic          s_ovld;
  logic [SW-1:0] s_lo, s_hi;
  logic [4:0]    s_loi, s_hii;

  exp_t b_q[$];
  exp_t s_q[$];
  int   b_issued = 0, b_seen = 0, s_issued = 0, s_seen = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  madd_split #(.W(BW)) i_madd_split (
    .clk(clk), .rst(rst), .in_vld(b_vld), .in_op(b_op), .in_a(b_a),
    .in_b(b_b), .in_c(b_c), .in_dst(b_dst), .out_vld(b_ovld),
    .out_lo(b_lo), .out_hi(b_hi), .out_lo_idx(b_loi), .out_hi_idx(b_hii)
  );

  madd_split #(.W(SW)) i_madd_split_small (
    .clk(clk), .rst(rst), .in_vld(s_vld), .in_op(s_op), .in_a(s_a),
    .in_b(s_b), .in_c(s_c), .in_dst(s_dst), .out_vld(s_ovld),
    .out_lo(s_lo), .out_hi(s_hi), .out_lo_idx(s_loi), .out_hi_idx(s_hii)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // wide monitor
  logic [BW-1:0] b_plo = '0, b_phi = '0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (b_q.size() > 0 && b_q[0].due == cyc) begin
        exp_t e;
        e = b_q.pop_front();
        chk(b_ovld, "R3 wide valid on time", 128'(b_ovld), 128'(1));
        chk(b_lo == e.val[63:0], "R1/R2 wide low word", 128'(b_lo), 128'(e.val[63:0]));
        chk(b_hi == e.val[127:64], "R1/R2 wide high word", 128'(b_hi), 128'(e.val[127:64]));
        chk(b_loi == e.idx && b_hii == e.idx + 5'd1, "R6 wide index pair",
            128'({b_hii, b_loi}), 128'({e.idx + 5'd1, e.idx}));
        b_seen++;
      end else begin
        chk(!b_ovld, "R3/R5 wide no unexpected valid", 128'(b_ovld), 128'(0));
        chk(b_lo == b_plo && b_hi == b_phi, "R8 wide hold", {b_hi, b_lo}, {b_phi, b_plo});
      end
    end
    b_plo <= b_lo;
    b_phi <= b_hi;
  end

  // small monitor
  logic [SW-1:0] s_plo = '0, s_phi = '0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (s_q.size() > 0 && s_q[0].due == cyc) begin
        exp_t e;
        e = s_q.pop_front();
        chk(s_ovld, "R3 small valid on time", 128'(s_ovld), 128'(1));
        chk({s_hi, s_lo} == e.val[7:0], "R1/R2 small result", 128'({s_hi, s_lo}),
            128'(e.val[7:0]));
        chk(s_loi == e.idx && s_hii == e.idx + 5'd1, "R6 small index pair",
            128'({s_hii, s_loi}), 128'({e.idx + 5'd1, e.idx}));
        s_seen++;
      end else begin
        chk(!s_ovld, "R3/R5 small no unexpected valid", 128'(s_ovld), 128'(0));
        chk(s_lo == s_plo && s_hi == s_phi, "R8 small hold", 128'({s_hi, s_lo}),
            128'({s_phi, s_plo}));
      end
    end
    s_plo <= s_lo;
    s_phi <= s_hi;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 128'(cyc), 128'(0));
      finish_run();
    end
  end

  function automatic logic [63:0] corner(input int k);
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'h0000_0001_0000_0000;
    endcase
  endfunction

  task automatic drive_wide();
    int n = 0;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (n % 5 == 2) begin          // R5: wrong selector, ignored
            b_vld = 1'b1; b_op = OPC ^ 6'b000100;
            @(negedge clk);
          end
          b_vld = 1'b1; b_op = OPC;    // R4: otherwise back-to-back
          b_a = corner(i); b_b = corner(j); b_c = corner(k); b_dst = 5'(n + 29);
          b_q.push_back('{cyc + 3,
            ({64'd0, corner(i)} * {64'd0, corner(j)}) + {64'd0, corner(k)}, 5'(n + 29)});
          b_issued++;
          n++;
        end
    @(negedge clk);
    b_vld = 1'b0;
  endtask

  task automatic drive_small();
    int n = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          if (n % 7 == 3) begin          // R5: request low, ignored
            s_vld = 1'b0;
            @(negedge clk);
          end
          s_vld = 1'b1; s_op = OPC;
          s_a = 4'(a); s_b = 4'(b); s_c = 4'(c); s_dst = 5'(n);
          s_q.push_back('{cyc + 3, 128'(a * b + c), 5'(n)});
          s_issued++;
          n++;
        end
    @(negedge clk);
    s_vld = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R7: cleared by the synchronous reset
    chk(!b_ovld && b_lo == '0 && b_hi == '0 && b_loi == '0 && b_hii == '0,
        "R7 wide reset state", {b_hi, b_lo}, 128'(0));
    chk(!s_ovld && s_lo == '0 && s_hi == '0 && s_loi == '0 && s_hii == '0,
        "R7 small reset state", 128'({s_hi, s_lo}), 128'(0));
    mon_on = 1'b1;
    fork
      drive_wide();
      drive_small();
    join
    repeat (6) @(negedge clk);
    chk(b_seen == b_issued && b_q.size() == 0, "R4 wide all delivered",
        128'(b_seen), 128'(b_issued));
    chk(s_seen == s_issued && s_q.size() == 0, "R4 small all delivered",
        128'(s_seen), 128'(s_issued));

    // R5 directed: wrong selector with request high leaves outputs untouched
    begin
      logic [BW-1:0] lo0, hi0;
      lo0 = b_lo; hi0 = b_hi;
      b_vld = 1'b1; b_op = 6'b110011; b_a = '1; b_b = 64'd7; b_c = 64'd9;
      @(negedge clk);
      b_vld = 1'b0;
      repeat (4) @(negedge clk);
      chk(!b_ovld && b_lo == lo0 && b_hi == hi0, "R5 rejected selector",
          {b_hi, b_lo}, {hi0, lo0});
    end

    // R9 directed: all-ones operands
    b_vld = 1'b1; b_op = OPC; b_a = '1; b_b = '1; b_c = '1; b_dst = 5'd31;
    b_q.push_back('{cyc + 3, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, 5'd31});
    @(negedge clk);
    b_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk(b_ovld && b_hi == '1 && b_lo == '0, "R9 top of range",
        {b_hi, b_lo}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
    chk(b_hii == 5'd0, "R6 index wraps", 128'(b_hii), 128'(0));
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule